// File: doc/BRIEF.md
# Masked Sticky Interrupt Collector

This block gathers a set of internal condition lines into sticky status bits and drives one interrupt request pin from them. A status bit does not follow the level of its condition. It is set when the condition goes from 0 to 1 while the matching enable (mask) bit is 1, and it then stays set until it is cleared. A condition that is already true when its enable is switched on, or when its status is cleared, does not set the bit again. A new rising transition is needed for that.

Software clears status bits in two ways. It can send a one-cycle clear strobe for each bit, or a one-cycle clear-all strobe that clears every bit. A board-level clear-all pin, passed through a small synchronizer, does the same as the clear-all strobe. The request pin is asserted as long as any status bit is set. A two-bit mode selects how it is driven: open-drain style active low, open-drain style active high, push-pull active high, or push-pull active low. The pin is presented as an output value plus an output enable. The bus decode and the register map are outside the block, so the mask, the clear strobes, the mode and the status connect straight to ports.

Top module: `irq_collector`

## Requirements
- R1: The pin follows `mode_i`, with "asserted" meaning at least one status bit is 1. 00: `pin_oe`=asserted, `pin_out`=0. 01: `pin_oe`=asserted, `pin_out`=1. 10: `pin_oe`=1, `pin_out`=asserted. 11: `pin_oe`=1, `pin_out`=not asserted.
- R2: After synchronous active-low reset every status bit is 0. With mode 00, which is the idle encoding, the pin is then not driven (`pin_oe`=0).
- R3: A 0-to-1 change on `cond_i[k]` before clock edge e sets `status_o[k]` at edge e+1, provided `mask_i[k]` is 1 at edge e+1. Holding the condition high does not raise it again.
- R4: An event on bit k whose `mask_i[k]` is 0 leaves `status_o[k]` at 0.
- R5: Changing `mask_i[k]` from 1 to 0 does not clear a `status_o[k]` that is already set.
- R6: The request is the OR of all status bits. Several bits may be set together, and the pin stays asserted until the last one is cleared.
- R7: A one-cycle pulse on `clr_i[k]` clears only `status_o[k]`, at the next edge.
- R8: A one-cycle pulse on `clr_all_i` clears every status bit at the next edge.
- R9: A one-cycle pulse on `clr_all_pin_i` passes through PIN_SYNC flops and then clears every status bit. With PIN_SYNC=2, a pulse driven before edge a takes effect at edge a+2.
- R10: A condition that is already high when its mask is enabled, or when its bit is cleared, does not set the status bit.
- R11: When a clear (per-bit or clear-all) and a new event for the same bit fall in the same cycle, the event wins and the bit is 1 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_i | input | N | Internal condition lines |
| mask_i | input | N | Per-bit event enables |
| clr_i | input | N | Per-bit one-cycle clear strobes |
| clr_all_i | input | 1 | One-cycle clear-all strobe |
| clr_all_pin_i | input | 1 | Asynchronous clear-all pin |
| mode_i | input | 2 | Pin drive mode |
| status_o | output | N | Sticky status bits |
| pin_out | output | 1 | Value driven on the request pin |
| pin_oe | output | 1 | Output enable of the request pin |

## Verification
The hardest cases to reach are a clear and a fresh rising event landing on the same bit in the same cycle, and a mask being enabled while its condition is already high. Both depend on the two-edge gap between a condition change and the resulting event. The stimulus table is laid out with that delay in mind. A condition toggles one row ahead of the row that carries the clear or the mask change, so the event and the clear or enable reach the status register at the same edge. The synchronized pin clear is checked on each cycle of its delay, so that a wrong stage count shows up.

// File: rtl/irq_collector_pkg.sv
// Package: shared types of the interrupt collector.
// Assumes: the encoding of the pin mode is fixed by the pin behaviour it selects.
package irq_collector_pkg;

    typedef enum logic [1:0] {
        PIN_OD_ACT_LOW  = 2'b00,
        PIN_OD_ACT_HIGH = 2'b01,
        PIN_PP_ACT_HIGH = 2'b10,
        PIN_PP_ACT_LOW  = 2'b11
    } pin_mode_e;

endpackage

// File: rtl/irq_edge_capture.sv
// Registers the condition lines and flags a rising transition on each one.
// Assumes: conditions come from the same clock domain. An event is a
// registered sample of 1 whose previous sample was 0.
module irq_edge_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] cond_q;
    logic [N-1:0] cond_prev;

    // Keep the current and previous condition samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q    <= '0;
            cond_prev <= '0;
        end else begin
            cond_q    <= cond_i;
            cond_prev <= cond_q;
        end
    end

    // Mark each bit whose sample rose since the previous one.
    always_comb begin
        rise_o = cond_q & ~cond_prev;
    end
endmodule

// File: rtl/irq_pin_sync.sv
// Synchronizer for the external clear-all pin.
// Assumes: the pin is asynchronous and held for at least one clock period.
// STAGES flops give STAGES cycles of delay.
module irq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] shreg;

    generate
        if (STAGES == 1) begin : g_single
            // Single stage: sample the pin directly.
            always_ff @(posedge clk) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= async_i;
            end
        end else begin : g_chain
            // Shift the pin through the stage chain.
            always_ff @(posedge clk) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= {shreg[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = shreg[STAGES-1];
endmodule

// File: rtl/irq_status_bank.sv
// Sticky status bits: set on masked events, cleared by strobes.
// Assumes: clear strobes are single-cycle pulses. A new event beats any
// clear in the same cycle.
module irq_status_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] mask_i,
    input  logic [N-1:0] clr_i,
    input  logic         clr_all_i,
    output logic [N-1:0] status_o
);
    logic [N-1:0] set_vec;
    logic [N-1:0] keep_vec;
    logic [N-1:0] status_q;

    // Events that pass the mask, and bits that survive the clears.
    always_comb begin
        set_vec  = rise_i & mask_i;
        keep_vec = status_q & ~clr_i & {N{~clr_all_i}};
    end

    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_bit
            // Update one sticky bit, giving a new event priority over clears.
            always_ff @(posedge clk) begin
                if (!rst_n)          status_q[k] <= 1'b0;
                else if (set_vec[k]) status_q[k] <= 1'b1;
                else                 status_q[k] <= keep_vec[k];
            end
        end
    endgenerate

    assign status_o = status_q;
endmodule

// File: rtl/irq_pin_driver.sv
// Turns the status vector into the request pin value and enable.
// Assumes: combinational output; any external pull resistor sets the idle
// level in the open-drain style modes.
module irq_pin_driver
    import irq_collector_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] status_i,
    input  logic [1:0]   mode_i,
    output logic         pin_out,
    output logic         pin_oe
);
    logic      active;
    pin_mode_e mode;

    // Request is asserted while any status bit is set; decode the mode.
    always_comb begin
        active = |status_i;
        mode   = pin_mode_e'(mode_i);
    end

    // Choose the pin value and enable for the selected drive style.
    always_comb begin
        unique case (mode)
            PIN_OD_ACT_LOW: begin
                pin_oe  = active;
                pin_out = 1'b0;
            end
            PIN_OD_ACT_HIGH: begin
                pin_oe  = active;
                pin_out = 1'b1;
            end
            PIN_PP_ACT_HIGH: begin
                pin_oe  = 1'b1;
                pin_out = active;
            end
            default: begin
                pin_oe  = 1'b1;
                pin_out = ~active;
            end
        endcase
    end
endmodule

// File: rtl/irq_collector.sv
// Top of the interrupt collector: edge capture, sticky status, clear-all
// pin synchronizer and pin driver.
// Assumes: one clock domain except clr_all_pin_i; synchronous active-low reset.
module irq_collector #(
    parameter int N        = 8,
    parameter int PIN_SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond_i,
    input  logic [N-1:0] mask_i,
    input  logic [N-1:0] clr_i,
    input  logic         clr_all_i,
    input  logic         clr_all_pin_i,
    input  logic [1:0]   mode_i,
    output logic [N-1:0] status_o,
    output logic         pin_out,
    output logic         pin_oe
);
    logic [N-1:0] rise;
    logic         pin_clr_sync;
    logic         clr_all_eff;

    irq_edge_capture #(.N(N)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (cond_i),
        .rise_o (rise)
    );

    irq_pin_sync #(.STAGES(PIN_SYNC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (clr_all_pin_i),
        .sync_o  (pin_clr_sync)
    );

    // Merge the register clear-all strobe with the synchronized pin.
    always_comb begin
        clr_all_eff = clr_all_i | pin_clr_sync;
    end

    irq_status_bank #(.N(N)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .mask_i    (mask_i),
        .clr_i     (clr_i),
        .clr_all_i (clr_all_eff),
        .status_o  (status_o)
    );

    irq_pin_driver #(.N(N)) u_pin (
        .status_i (status_o),
        .mode_i   (mode_i),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );
endmodule

// File: rtl/irq_collector_chk.sv
// Checker for the interrupt collector, bound to the top module.
// Assumes: access to the merged clear-all signal inside the top.
module irq_collector_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] mask_i,
    input logic [N-1:0] clr_i,
    input logic         clr_all_i,
    input logic         clr_all_eff,
    input logic [1:0]   mode_i,
    input logic [N-1:0] status_o,
    input logic         pin_out,
    input logic         pin_oe
);
    // R4: a bit can only become set if its mask was 1 at that edge.
    p_mask_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ~$past(status_o) & ~$past(mask_i)) == '0));

    // R5: without a clear, a set bit stays set, whatever its mask does.
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_all_eff |=> (($past(status_o) & ~$past(clr_i) & ~status_o) == '0));

    // R7: with every mask at 0, a strobed bit is 0 after the edge.
    p_bit_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |=> ((status_o & $past(clr_i)) == '0));

    // R8: clear-all with every mask at 0 empties the status.
    p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all_i && mask_i == '0) |=> (status_o == '0));

    // R1: open-drain style active low.
    p_mode_od_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00) |-> (pin_oe == (status_o != '0) && !pin_out));

    // R1: push-pull active high.
    p_mode_pp_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10) |-> (pin_oe && pin_out == (status_o != '0)));

    // R1: push-pull active low.
    p_mode_pp_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11) |-> (pin_oe && pin_out == (status_o == '0)));
endmodule

bind irq_collector irq_collector_chk #(.N(N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_i      (mask_i),
    .clr_i       (clr_i),
    .clr_all_i   (clr_all_i),
    .clr_all_eff (clr_all_eff),
    .mode_i      (mode_i),
    .status_o    (status_o),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe)
);

// File: tb/irq_collector_tb.sv
module irq_collector_tb;
    localparam int N = 4;
    localparam int PIN_SYNC = 2;
    localparam int ROWS = 17;

    // Row layout: {cond, mask, clr, clr_all, expected status after the edge}
    localparam logic [16:0] VEC [0:ROWS-1] = '{
        17'b0001_1111_0000_0_0000, // 0  R2 nothing yet
        17'b0001_1111_0000_0_0001, // 1  R3 rise captured
        17'b0001_1111_0000_0_0001, // 2  R3 level does not re-fire
        17'b0011_1111_0001_0_0000, // 3  R7 bit clear
        17'b0011_0001_0000_0_0000, // 4  R4 masked event
        17'b0011_1111_0000_0_0000, // 5  R10 pre-existing on enable
        17'b0100_1111_0000_0_0000, // 6
        17'b0100_1111_0000_0_0100, // 7  R3
        17'b1100_0000_0000_0_0100, // 8  R5 mask drop keeps bit
        17'b1100_1111_0000_0_1100, // 9  R6 two bits
        17'b0000_1111_0100_0_1000, // 10 R6 pin still asserted
        17'b0001_1111_1000_0_0000, // 11 R7
        17'b0001_1111_0001_0_0001, // 12 R11 event beats bit clear
        17'b0000_1111_0000_1_0000, // 13 R8 clear-all
        17'b0010_1111_0000_0_0000, // 14 R10 no event after clear
        17'b0010_1111_0000_1_0010, // 15 R11 event beats clear-all
        17'b0010_1111_0000_0_0010  // 16
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] cond_i = '0;
    logic [N-1:0] mask_i = '0;
    logic [N-1:0] clr_i = '0;
    logic         clr_all_i = 1'b0;
    logic         clr_all_pin_i = 1'b0;
    logic [1:0]   mode_i = 2'b00;
    logic [N-1:0] status_o;
    logic         pin_out;
    logic         pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_collector #(.N(N), .PIN_SYNC(PIN_SYNC)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cond_i        (cond_i),
        .mask_i        (mask_i),
        .clr_i         (clr_i),
        .clr_all_i     (clr_all_i),
        .clr_all_pin_i (clr_all_pin_i),
        .mode_i        (mode_i),
        .status_o      (status_o),
        .pin_out       (pin_out),
        .pin_oe        (pin_oe)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Expected {pin_out, pin_oe} from the mode table of R1.
    function automatic logic [1:0] pin_exp(input logic [1:0] m, input logic act);
        case (m)
            2'b00:   return {1'b0, act};
            2'b01:   return {1'b1, act};
            2'b10:   return {act, 1'b1};
            default: return {~act, 1'b1};
        endcase
    endfunction

    function automatic string row_tag(input int r);
        case (r)
            0:       return "R2";
            1, 2, 7: return "R3";
            3, 11:   return "R7";
            4:       return "R4";
            5, 14:   return "R10";
            8:       return "R5";
            9, 10:   return "R6";
            12, 15:  return "R11";
            13:      return "R8";
            default: return "R3";
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step();
        step();
        // R2: reset state
        check("R2", 32'(status_o), 32'h0);
        check("R2", 32'(pin_oe), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < ROWS; i++) begin
            cond_i    = VEC[i][16:13];
            mask_i    = VEC[i][12:9];
            clr_i     = VEC[i][8:5];
            clr_all_i = VEC[i][4];
            mode_i    = 2'(i % 4);
            step();
            check(row_tag(i), 32'(status_o), 32'(VEC[i][3:0]));
            // R1 and R6: pin follows the OR of status in the current mode
            check("R1", 32'({pin_out, pin_oe}), 32'(pin_exp(mode_i, VEC[i][3:0] != '0)));
            clr_i     = '0;
            clr_all_i = 1'b0;
        end

        // R1: every mode while idle (status still 0010 -> set status first cleared below)
        // R9: pin clear through the synchronizer
        mode_i = 2'b00;
        clr_all_pin_i = 1'b1;
        step();
        clr_all_pin_i = 1'b0;
        check("R9", 32'(status_o), 32'h2);
        step();
        check("R9", 32'(status_o), 32'h2);
        step();
        check("R9", 32'(status_o), 32'h0);

        for (int m = 0; m < 4; m++) begin
            mode_i = 2'(m);
            #1;
            check("R1", 32'({pin_out, pin_oe}), 32'(pin_exp(2'(m), 1'b0)));
        end

        // R3 then R2: new event, then reset in mid-run
        mode_i = 2'b00;
        cond_i = 4'b0011;
        step();
        step();
        check("R3", 32'(status_o), 32'h1);
        check("R1", 32'({pin_out, pin_oe}), 32'b01);
        rst_n = 1'b0;
        step();
        check("R2", 32'(status_o), 32'h0);
        check("R2", 32'(pin_oe), 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule